// File: doc/BRIEF.md
# Break-Gated Channel Output Off-State Controller

This block sits between a timer channel's waveform logic and its pair of output pins (a true leg and an optional complementary leg). It gets the channel's active or inactive state and its reference waveform. For each leg it produces a pin value and a drive-enable, where a low enable releases the pin to high impedance. A main output enable, set by a software write, selects between run behaviour and idle behaviour. Two off-state select bits then choose, in each of these modes, whether an inactive leg is released or driven to a defined level.

An external break pin and a clock-failure event can clear the main output enable. The break pin passes through a synchronizer before it is compared with a programmable polarity. A break enable bit gates both break sources. Polarity and enable are written through a small configuration port and only take effect one clock after the write. A parameter removes the complementary leg for channels that do not have one.

Top module: `brk_offstate_ctrl`

## Requirements
- R1: After reset the main enable reads 0, the effective break polarity and break enable are 0, and both drive-enables are 0.
- R2: The break pin is synchronized by SYNC_STAGES flops (default 2). With effective polarity 0 a low synchronized pin counts as a break, and with polarity 1 a high pin does. A pin change driven before edge 1 clears the main enable at edge 3, and not before.
- R3: When the effective break enable is 0, neither the break pin nor the clock-failure input can clear the main enable. When it is 1, an asserted clock-failure input clears it one edge later.
- R4: A write on the configuration port (cfg_wr with cfg_pol, cfg_brk_en) is captured at the write edge and becomes effective one edge after that, so a break it enables clears the main enable two edges after the write edge.
- R5: A set_main pulse sets the main enable at the next edge. A break active in the same cycle wins and keeps it at 0. Once set, the main enable clears only on a break.
- R6: With the main enable at 1 and ch_active=1, the true leg drives ref_wave and the complementary leg drives its inverse. Each leg is enabled only when its own enable bit (en_p or en_n) is set.
- R7: With the main enable at 1, ch_active=0 and run_off_sel=0, both drive-enables are 0.
- R8: With the main enable at 1, ch_active=0, run_off_sel=1 and en_p or en_n set, both legs are enabled and drive 0.
- R9: With the main enable at 0 and idle_off_sel=0, both drive-enables are 0.
- R10: With the main enable at 0, idle_off_sel=1 and en_p or en_n set, both legs are enabled and drive idle_lvl_p and idle_lvl_n.
- R11: With HAS_COMP=0 the complementary leg is never enabled, and en_n and run_off_sel have no effect. An inactive true leg in run mode is enabled by en_p and drives 0.
- R12: A leg whose drive-enable is 0 presents value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pin | input | 1 | Raw external break pin |
| clk_fail | input | 1 | Clock-failure event |
| cfg_wr | input | 1 | Write strobe for break polarity and enable |
| cfg_pol | input | 1 | Break polarity to write (1 = active high) |
| cfg_brk_en | input | 1 | Break enable to write |
| set_main | input | 1 | Software write that sets the main enable |
| run_off_sel | input | 1 | Off-state select for run mode |
| idle_off_sel | input | 1 | Off-state select for idle mode |
| en_p | input | 1 | True leg enable bit |
| en_n | input | 1 | Complementary leg enable bit |
| idle_lvl_p | input | 1 | Idle level of the true leg (static) |
| idle_lvl_n | input | 1 | Idle level of the complementary leg (static) |
| ch_active | input | 1 | Channel active state |
| ref_wave | input | 1 | Channel reference waveform |
| main_en | output | 1 | Main output enable |
| out_p | output | 1 | True leg value |
| oe_p | output | 1 | True leg drive-enable (0 = high-Z) |
| out_n | output | 1 | Complementary leg value |
| oe_n | output | 1 | Complementary leg drive-enable (0 = high-Z) |

## Verification
The bench times a break pin edge through the synchronizer and checks that the main enable survives edge 2 and falls at edge 3. A design with one flop too few or too many fails that check. It writes polarity and enable at runtime and checks one cycle after the write edge that no break has taken effect yet, which catches a design that applies the write on the write edge itself. It holds both break sources asserted with the enable off, and collides set_main with an active break, to catch gating or priority mistakes. Every off-state combination runs against both a paired and an unpaired instance, which exposes a run select that still acts on a lone leg or a released leg that leaks a value.

// File: rtl/brk_offstate_pkg.sv
package brk_offstate_pkg;

  typedef struct packed {
    logic val;
    logic oe;
  } leg_t;

  // break condition from a synchronized sample under the effective config
  function automatic logic brk_hit(input logic pin_s, input logic fail,
                                   input logic pol, input logic en);
    logic pin_act;
    pin_act = pol ? pin_s : ~pin_s;
    return en & (pin_act | fail);
  endfunction

endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/brk_cfg.sv
module brk_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic pol_in,
  input  logic en_in,
  output logic pol_eff,
  output logic en_eff
);
  logic pol_sh, en_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_sh  <= 1'b0;
      en_sh   <= 1'b0;
      pol_eff <= 1'b0;
      en_eff  <= 1'b0;
    end else begin
      if (wr) begin
        pol_sh <= pol_in;
        en_sh  <= en_in;
      end
      pol_eff <= pol_sh;
      en_eff  <= en_sh;
    end
  end

  // R4: written value visible exactly two edges after the write cycle
  p_cfg_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ##1 (pol_eff == $past(pol_in, 2) && en_eff == $past(en_in, 2)));
endmodule

// File: rtl/moe_ctrl.sv
module moe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_active,
  input  logic set_req,
  output logic moe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          moe <= 1'b0;
    else if (brk_active) moe <= 1'b0;
    else if (set_req)    moe <= 1'b1;
  end

  p_brk_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |=> !moe);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !brk_active) |=> moe);
  p_only_brk_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(moe) |-> $past(brk_active));
endmodule

// File: rtl/off_state_mux.sv
module off_state_mux
  import brk_offstate_pkg::*;
#(
  parameter int HAS_COMP = 1
) (
  input  logic moe,
  input  logic ch_active,
  input  logic ref_wave,
  input  logic run_off_sel,
  input  logic idle_off_sel,
  input  logic en_p,
  input  logic en_n,
  input  logic idle_lvl_p,
  input  logic idle_lvl_n,
  output leg_t leg_p,
  output leg_t leg_n
);
  localparam bit COMP = (HAS_COMP != 0);

  logic any_en;
  leg_t p_c, n_c;

  assign any_en = en_p | (COMP & en_n);

  always_comb begin
    p_c = '0;
    n_c = '0;
    if (moe) begin
      if (ch_active) begin
        p_c.oe  = en_p;
        p_c.val = en_p & ref_wave;
        n_c.oe  = en_n;
        n_c.val = en_n & ~ref_wave;
      end else if (COMP && run_off_sel && any_en) begin
        p_c.oe = 1'b1;
        n_c.oe = 1'b1;
      end else if (!COMP) begin
        p_c.oe = en_p;
      end
    end else if (idle_off_sel && any_en) begin
      p_c.oe  = 1'b1;
      p_c.val = idle_lvl_p;
      n_c.oe  = 1'b1;
      n_c.val = idle_lvl_n;
    end
  end

  assign leg_p = p_c;

  generate
    if (COMP) begin : g_comp
      assign leg_n = n_c;
    end else begin : g_nocomp
      assign leg_n = '0;
    end
  endgenerate

  always_comb begin
    a_released_zero_r12: assert (leg_p.oe || !leg_p.val);
    a_released_zero_n_r12: assert (leg_n.oe || !leg_n.val);
    if (!moe && !idle_off_sel) a_idle_hiz_r9: assert (!leg_p.oe && !leg_n.oe);
    if (moe && !ch_active && !run_off_sel && COMP) a_run_hiz_r7: assert (!leg_p.oe && !leg_n.oe);
    if (!COMP) a_no_comp_r11: assert (!leg_n.oe);
  end
endmodule

// File: rtl/brk_offstate_ctrl.sv
module brk_offstate_ctrl
  import brk_offstate_pkg::*;
#(
  parameter int HAS_COMP    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_pin,
  input  logic clk_fail,
  input  logic cfg_wr,
  input  logic cfg_pol,
  input  logic cfg_brk_en,
  input  logic set_main,
  input  logic run_off_sel,
  input  logic idle_off_sel,
  input  logic en_p,
  input  logic en_n,
  input  logic idle_lvl_p,
  input  logic idle_lvl_n,
  input  logic ch_active,
  input  logic ref_wave,
  output logic main_en,
  output logic out_p,
  output logic oe_p,
  output logic out_n,
  output logic oe_n
);
  logic pin_s, pol_eff, en_eff, brk_active;
  leg_t leg_p, leg_n;

  brk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(brk_pin), .q(pin_s));

  brk_cfg i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .pol_in(cfg_pol),
    .en_in(cfg_brk_en), .pol_eff(pol_eff), .en_eff(en_eff));

  assign brk_active = brk_hit(pin_s, clk_fail, pol_eff, en_eff);

  moe_ctrl i_moe (
    .clk(clk), .rst_n(rst_n), .brk_active(brk_active),
    .set_req(set_main), .moe(main_en));

  off_state_mux #(.HAS_COMP(HAS_COMP)) i_mux (
    .moe(main_en), .ch_active(ch_active), .ref_wave(ref_wave),
    .run_off_sel(run_off_sel), .idle_off_sel(idle_off_sel),
    .en_p(en_p), .en_n(en_n), .idle_lvl_p(idle_lvl_p),
    .idle_lvl_n(idle_lvl_n), .leg_p(leg_p), .leg_n(leg_n));

  assign out_p = leg_p.val;
  assign oe_p  = leg_p.oe;
  assign out_n = leg_n.val;
  assign oe_n  = leg_n.oe;

  // R3: with the break gate off, a set main enable survives any pin or failure
  p_gate_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_eff && main_en) |=> main_en);
  // R2: a pin sample in break state under enable clears main enable next edge
  p_pin_break_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && (pin_s == pol_eff)) |=> !main_en);
endmodule

// File: tb/test_brk_offstate_ctrl.sv
`timescale 1ns/1ps
module test_brk_offstate_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic brk_pin = 1'b1, clk_fail = 1'b0, cfg_wr = 1'b0, cfg_pol = 1'b0, cfg_brk_en = 1'b0;
  logic set_main = 1'b0, run_off_sel = 1'b0, idle_off_sel = 1'b0;
  logic en_p = 1'b0, en_n = 1'b0, idle_lvl_p = 1'b0, idle_lvl_n = 1'b0;
  logic ch_active = 1'b0, ref_wave = 1'b0;
  logic main_en, out_p, oe_p, out_n, oe_n;
  logic main_en2, out_p2, oe_p2, out_n2, oe_n2;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brk_offstate_ctrl i_brk_offstate_ctrl (
    .clk, .rst_n, .brk_pin, .clk_fail, .cfg_wr, .cfg_pol, .cfg_brk_en, .set_main,
    .run_off_sel, .idle_off_sel, .en_p, .en_n, .idle_lvl_p, .idle_lvl_n,
    .ch_active, .ref_wave, .main_en, .out_p, .oe_p, .out_n, .oe_n);

  brk_offstate_ctrl #(.HAS_COMP(0)) i_brk_offstate_ctrl_nc (
    .clk, .rst_n, .brk_pin, .clk_fail, .cfg_wr, .cfg_pol, .cfg_brk_en, .set_main,
    .run_off_sel, .idle_off_sel, .en_p, .en_n, .idle_lvl_p, .idle_lvl_n,
    .ch_active, .ref_wave, .main_en(main_en2), .out_p(out_p2), .oe_p(oe_p2),
    .out_n(out_n2), .oe_n(oe_n2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int q_sync[$];
  int m_pol_w = 0, m_en_w = 0, m_pol = 0, m_en = 0, m_moe = 0;

  always @(posedge clk) begin
    int hit;
    if (!rst_n) begin
      q_sync = {0, 0}; m_pol_w = 0; m_en_w = 0; m_pol = 0; m_en = 0; m_moe = 0;
    end else begin
      hit = m_en && (((m_pol != 0) == (q_sync[0] != 0)) || clk_fail);
      if (hit) m_moe = 0;
      else if (set_main) m_moe = 1;
      m_pol = m_pol_w; m_en = m_en_w;
      if (cfg_wr) begin m_pol_w = cfg_pol; m_en_w = cfg_brk_en; end
      void'(q_sync.pop_front());
      q_sync.push_back(int'(brk_pin));
    end
  end

  // expected {out_p, oe_p, out_n, oe_n} as an integer code
  function automatic int expect_legs(input int moe, input int comp);
    int ep, en, vp, vn;
    ep = 0; en = 0; vp = 0; vn = 0;
    if (moe == 1 && ch_active) begin
      ep = en_p; vp = en_p ? ref_wave : 0;
      en = comp ? en_n : 0; vn = en ? !ref_wave : 0;
    end else if (moe == 1 && comp == 0) begin
      ep = en_p;
    end else if (moe == 1) begin
      if (run_off_sel && (en_p || en_n)) begin ep = 1; en = 1; end
    end else if (idle_off_sel && (en_p || (comp && en_n))) begin
      ep = 1; vp = idle_lvl_p;
      if (comp) begin en = 1; vn = idle_lvl_n; end
    end
    return vp * 8 + ep * 4 + vn * 2 + en;
  endfunction

  function automatic string mode_tag(input int comp);
    if (comp == 0) return "R11";
    if (m_moe == 0) return idle_off_sel ? "R10" : "R9";
    if (ch_active) return "R6";
    return run_off_sel ? "R8" : "R7";
  endfunction

  always @(posedge clk) begin
    int a1, a2, e1, e2;
    #1;
    if (rst_n && !done) begin
      chk(main_en == m_moe[0], "R5", main_en, m_moe);
      chk(main_en2 == m_moe[0], "R5", main_en2, m_moe);
      a1 = out_p * 8 + oe_p * 4 + out_n * 2 + oe_n;
      a2 = out_p2 * 8 + oe_p2 * 4 + out_n2 * 2 + oe_n2;
      e1 = expect_legs(m_moe, 1);
      e2 = expect_legs(m_moe, 0);
      chk(a1 == e1, mode_tag(1), a1, e1);
      chk(a2 == e2, mode_tag(0), a2, e2);
      chk((oe_p || !out_p) && (oe_n || !out_n), "R12", a1, e1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic p, input logic e);
    cfg_wr = 1'b1; cfg_pol = p; cfg_brk_en = e;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_set();
    set_main = 1'b1; cyc(1); set_main = 1'b0;
  endtask

  task automatic sweep_legs();
    for (int k = 0; k < 32; k++) begin
      {ch_active, run_off_sel, en_p, en_n, ref_wave} = 5'(k);
      cyc(1);
    end
    for (int k = 0; k < 16; k++) begin
      {idle_off_sel, idle_lvl_p, idle_lvl_n, en_p} = 4'(k);
      en_n = ~en_p ^ k[0];
      cyc(1);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(main_en == 1'b0, "R1", main_en, 0);
    chk(!oe_p && !oe_n, "R1", oe_p + oe_n, 0);
    // idle mode sweep (main enable off)
    sweep_legs();
    // R5 set main enable
    pulse_set();
    chk(main_en == 1'b1, "R5", main_en, 1);
    sweep_legs();
    // R3: gate off, both sources asserted (pin low = active for pol 0)
    brk_pin = 1'b0; clk_fail = 1'b1;
    cyc(6);
    chk(main_en == 1'b1, "R3", main_en, 1);
    brk_pin = 1'b1; clk_fail = 1'b0;
    cyc(3);
    // R4: enable with pol 0 (pin high = quiet), then flip polarity to 1
    write_cfg(1'b0, 1'b1);
    cyc(3);
    chk(main_en == 1'b1, "R4", main_en, 1);
    cfg_wr = 1'b1; cfg_pol = 1'b1; cfg_brk_en = 1'b1;
    cyc(1);
    cfg_wr = 1'b0;
    chk(main_en == 1'b1, "R4", main_en, 1);
    cyc(1);
    chk(main_en == 1'b1, "R4", main_en, 1);
    cyc(1);
    chk(main_en == 1'b0, "R4", main_en, 0);
    // R5: set while break active loses
    pulse_set();
    chk(main_en == 1'b0, "R5", main_en, 0);
    // R2: polarity 1, pin low quiet, then rising pin
    brk_pin = 1'b0;
    cyc(3);
    pulse_set();
    chk(main_en == 1'b1, "R2", main_en, 1);
    brk_pin = 1'b1;
    cyc(2);
    chk(main_en == 1'b1, "R2", main_en, 1);
    cyc(1);
    chk(main_en == 1'b0, "R2", main_en, 0);
    sweep_legs();
    // R2: polarity 0, falling pin
    write_cfg(1'b0, 1'b1);
    cyc(3);
    pulse_set();
    chk(main_en == 1'b1, "R2", main_en, 1);
    brk_pin = 1'b0;
    cyc(2);
    chk(main_en == 1'b1, "R2", main_en, 1);
    cyc(1);
    chk(main_en == 1'b0, "R2", main_en, 0);
    brk_pin = 1'b1;
    cyc(3);
    // R3: clock failure with gate on
    pulse_set();
    chk(main_en == 1'b1, "R3", main_en, 1);
    clk_fail = 1'b1;
    cyc(1);
    chk(main_en == 1'b0, "R3", main_en, 0);
    clk_fail = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule